// File: doc/BRIEF.md
# Fail-Safe System Clock Selector

This block picks the source of two derived clocks. The main clock can come from the internal DCO, the XT1 crystal or the XT2 crystal. The sub-system clock can come from the DCO or XT2. Software programs both selections through a small register interface that runs on a separate control clock. Every change of effective source goes through a glitch-free switch.

Four oscillator fault indications arrive as asynchronous inputs. Any one of them latches a global fault flag. Reset also sets this flag. While the flag is set, the main clock runs from the DCO. The stored main select is not changed by this override. When software clears the flag, the programmed source takes over again. If the fault interrupt enable is set while the flag is set, a non-maskable interrupt request is raised. An acknowledge pulse clears the enable.

Top module: `failsafe_clksel`

## Requirements
- R1: After reset the control register (read address 0) reads 0x00, the status register (read address 1) reads 0x01 with the flag set, the interrupt request is low, and both clocks run from the DCO.
- R2: Control is bits [1:0] main select, bit 2 sub select and bit 3 interrupt enable. Status is bit 0 flag and bits [4:1] the synchronized values of osc_fault[3:0]. osc_fault bit 0 is the low-frequency fault, bit 1 XT1, bit 2 XT2 and bit 3 DCO. Any asserted fault bit sets the flag within three control-clock cycles, and the flag stays set after the fault goes away.
- R3: While the flag is set, the main clock follows the DCO whatever the main select holds.
- R4: The override leaves the stored main select unchanged. Main select 00 gives the DCO, 01 XT1 and 10 XT2, and the programmed source drives the main clock once the flag is clear.
- R5: Writing status with bit 0 = 0 clears the flag and writing 1 sets it. A fault still asserted in the cycle of the clearing write wins, so the flag stays set.
- R6: The interrupt request is high exactly when both the flag and the interrupt enable are set.
- R7: A one-cycle pulse on nmi_ack clears the interrupt enable on the next edge. The acknowledge wins over a write in the same cycle.
- R8: Sub select 0 gives the DCO and 1 gives XT2 on the sub-system clock. The fault flag has no effect on this choice.
- R9: A source switch produces no pulse shorter than the shortest half period of the sources. A clock's enable rises only while every other enable is low.
- R10: Main select encoding 11 selects the DCO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control/register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_dco | input | 1 | Internal DCO clock |
| clk_xt1 | input | 1 | XT1 crystal clock |
| clk_xt2 | input | 1 | XT2 crystal clock |
| osc_fault | input | 4 | Asynchronous fault indications: [0] low-freq, [1] XT1, [2] XT2, [3] DCO |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 1 | Write address: 0 control, 1 status |
| reg_wdata | input | 4 | Write data |
| reg_raddr | input | 1 | Read address: 0 control, 1 status |
| reg_rdata | output | 8 | Read data |
| nmi_ack | input | 1 | Interrupt grant pulse |
| nmi_req | output | 1 | Non-maskable interrupt request |
| mclk | output | 1 | Main clock |
| smclk | output | 1 | Sub-system clock |

## Verification
The three sources have distinct periods: 8 ns for the DCO, 30 ns for XT1 and 14 ns for XT2. The bench therefore identifies the main-clock source by measuring its period after each selection. This tells the override apart from a normal selection, and encoding 11 apart from 01 and 10. Each fault bit is raised alone, so the readback shows that the cause lands in its own position and that the flag latches after the fault drops. A clearing write made while a fault is held distinguishes set-priority from clear-priority. Enabling the interrupt with the flag clear, then setting the flag, then acknowledging, separates the AND of flag and enable from either term alone. A pulse-width monitor that runs for the whole test exposes any runt pulse during a switch.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
// Shared encodings and sizes for the fail-safe clock selector.
package clksel_pkg;
    typedef enum logic [1:0] {
        MSRC_DCO     = 2'b00,
        MSRC_XT1     = 2'b01,
        MSRC_XT2     = 2'b10,
        MSRC_DCO_ALT = 2'b11
    } msrc_e;

    localparam int NUM_FAULT = 4;
    localparam int WDATA_W   = 4;
    localparam int RDATA_W   = 8;
    localparam int NUM_MSRC  = 3;
    localparam int NUM_SSRC  = 2;
endpackage

// File: rtl/clksel_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a vector of asynchronous level signals.
// Assumes each bit is a slow level; bits are not coherent with each other.
module clksel_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    // shift the input through the synchronizer stages
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/clksel_gfmux.sv
`timescale 1ns/1ps
// Glitch-free N-way clock multiplexer.
// Each source has a two-stage enable synchronizer clocked on its own falling
// edge. A lane requests its enable only while every other enable is low.
// Assumes sel_oh is one-hot and changes slowly relative to all sources.
module clksel_gfmux #(
    parameter int N = 3
) (
    input  logic [N-1:0] clk_src,
    input  logic         rst_n,
    input  logic [N-1:0] sel_oh,
    output logic         clk_out
);
    logic [N-1:0] en;
    logic [N-1:0] req;
    logic [N-1:0] gated;

    // a lane asks for its clock only when it is selected and all others are off
    always_comb begin
        for (int k = 0; k < N; k++) begin
            req[k] = sel_oh[k] && ((en & ~(N'(1) << k)) == '0);
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_lane
        localparam logic [N-1:0] OTHERS = ~(N'(1) << i);
        logic s1;
        logic en_l;

        // two falling-edge stages move the request into this source's domain
        always_ff @(negedge clk_src[i]) begin
            if (!rst_n) begin
                s1   <= 1'b0;
                en_l <= 1'b0;
            end else begin
                s1   <= req[i];
                en_l <= s1;
            end
        end

        assign en[i]    = en_l;
        assign gated[i] = clk_src[i] & en_l;

        // R9
        excl_enable_chk: assert property (@(posedge clk_src[i]) disable iff (!rst_n)
            $rose(en_l) |-> ((en & OTHERS) == '0));
    end

    assign clk_out = |gated;
endmodule

// File: rtl/clksel_regs.sv
`timescale 1ns/1ps
// Control/status registers, fault flag latch and interrupt handshake.
// Assumes fault_s is already synchronized to clk. Setting the flag takes
// priority over a software clear, and the acknowledge wins over an enable write.
module clksel_regs
    import clksel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 waddr,
    input  logic [WDATA_W-1:0]   wdata,
    input  logic                 raddr,
    output logic [RDATA_W-1:0]   rdata,
    input  logic [NUM_FAULT-1:0] fault_s,
    input  logic                 nmi_ack,
    output msrc_e                msel,
    output logic                 ssel,
    output logic                 flag,
    output logic                 nmi_req
);
    msrc_e msel_q;
    logic  ssel_q;
    logic  ie_q;
    logic  flag_q;
    logic  wr_ctrl;
    logic  wr_stat;

    assign wr_ctrl = wr_en && (waddr == 1'b0);
    assign wr_stat = wr_en && (waddr == 1'b1);

    // source selects and interrupt enable, with the acknowledge clearing the enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msel_q <= MSRC_DCO;
            ssel_q <= 1'b0;
            ie_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                msel_q <= msrc_e'(wdata[1:0]);
                ssel_q <= wdata[2];
                ie_q   <= wdata[3];
            end
            if (nmi_ack) ie_q <= 1'b0;
        end
    end

    // global fault flag: set on reset or fault, otherwise written by software
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b1;
        else if (|fault_s)   flag_q <= 1'b1;
        else if (wr_stat)    flag_q <= wdata[0];
    end

    // register readback
    always_comb begin
        if (raddr == 1'b0) rdata = RDATA_W'({ie_q, ssel_q, msel_q});
        else               rdata = RDATA_W'({fault_s, flag_q});
    end

    assign msel    = msel_q;
    assign ssel    = ssel_q;
    assign flag    = flag_q;
    assign nmi_req = flag_q && ie_q;

    // R2
    fault_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_s) |=> flag_q);

    // R5
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !wdata[0] && !(|fault_s)) |=> !flag_q);

    // R7
    ack_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_ack |=> !ie_q);

    // R4
    sel_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_q) && !wr_ctrl) |=> $stable(msel_q));
endmodule

// File: rtl/failsafe_clksel.sv
`timescale 1ns/1ps
// Fail-safe selector for the main and sub-system clocks.
// Synchronizes the fault inputs, keeps the register state, forces the main
// clock onto the DCO while the fault flag is set, and drives two glitch-free
// multiplexers. Assumes all source clocks run while rst_n is low.
module failsafe_clksel
    import clksel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_dco,
    input  logic                 clk_xt1,
    input  logic                 clk_xt2,
    input  logic [NUM_FAULT-1:0] osc_fault,
    input  logic                 reg_we,
    input  logic                 reg_waddr,
    input  logic [WDATA_W-1:0]   reg_wdata,
    input  logic                 reg_raddr,
    output logic [RDATA_W-1:0]   reg_rdata,
    input  logic                 nmi_ack,
    output logic                 nmi_req,
    output logic                 mclk,
    output logic                 smclk
);
    logic [NUM_FAULT-1:0] fault_s;
    msrc_e                msel;
    logic                 ssel;
    logic                 flag;
    logic [NUM_MSRC-1:0]  m_oh;
    logic [NUM_SSRC-1:0]  s_oh;

    clksel_sync #(.W(NUM_FAULT), .STAGES(2)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (osc_fault),
        .q     (fault_s)
    );

    clksel_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .waddr   (reg_waddr),
        .wdata   (reg_wdata),
        .raddr   (reg_raddr),
        .rdata   (reg_rdata),
        .fault_s (fault_s),
        .nmi_ack (nmi_ack),
        .msel    (msel),
        .ssel    (ssel),
        .flag    (flag),
        .nmi_req (nmi_req)
    );

    // effective main source: the DCO under fault, otherwise the programmed one
    always_comb begin
        m_oh = 3'b001;
        if (!flag) begin
            case (msel)
                MSRC_XT1: m_oh = 3'b010;
                MSRC_XT2: m_oh = 3'b100;
                default:  m_oh = 3'b001;
            endcase
        end
    end

    // sub-system source: DCO or XT2, never overridden
    always_comb s_oh = ssel ? 2'b10 : 2'b01;

    clksel_gfmux #(.N(NUM_MSRC)) i_mmux (
        .clk_src ({clk_xt2, clk_xt1, clk_dco}),
        .rst_n   (rst_n),
        .sel_oh  (m_oh),
        .clk_out (mclk)
    );

    clksel_gfmux #(.N(NUM_SSRC)) i_smux (
        .clk_src ({clk_xt2, clk_dco}),
        .rst_n   (rst_n),
        .sel_oh  (s_oh),
        .clk_out (smclk)
    );
endmodule

// File: tb/test_failsafe_clksel.sv
`timescale 1ns/1ps
module test_failsafe_clksel;
    localparam int CLK_PERIOD = 10;
    localparam int DCO_HALF   = 4;
    localparam int XT1_HALF   = 15;
    localparam int XT2_HALF   = 7;
    localparam int K_REG = 0, K_MPER = 1, K_SPER = 2, K_NMI = 3;

    logic clk = 0, clk_dco = 0, clk_xt1 = 0, clk_xt2 = 0;
    logic rst_n = 0;
    logic [3:0] osc_fault = '0;
    logic reg_we = 0, reg_waddr = 0, reg_raddr = 0, nmi_ack = 0;
    logic [3:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic nmi_req, mclk, smclk;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(DCO_HALF) clk_dco = ~clk_dco;
    always #(XT1_HALF) clk_xt1 = ~clk_xt1;
    always #(XT2_HALF) clk_xt2 = ~clk_xt2;

    failsafe_clksel i_failsafe_clksel (
        .clk(clk), .rst_n(rst_n), .clk_dco(clk_dco), .clk_xt1(clk_xt1),
        .clk_xt2(clk_xt2), .osc_fault(osc_fault), .reg_we(reg_we),
        .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
        .reg_rdata(reg_rdata), .nmi_ack(nmi_ack), .nmi_req(nmi_req),
        .mclk(mclk), .smclk(smclk)
    );

    typedef struct {
        int    kind;
        int    arg;
        int    exp;
        string req;
    } item_t;

    item_t sb[$];
    int pending = 0;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // driver side: queue an expectation
    task automatic push(input int kind, input int arg, input int exp, input string req);
        item_t it;
        it.kind = kind; it.arg = arg; it.exp = exp; it.req = req;
        sb.push_back(it);
        pending++;
    endtask

    task automatic drain();
        wait (pending == 0);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [3:0] d);
        @(negedge clk);
        reg_we = 1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic compare(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // monitor side: take the oldest expectation, observe, compare, pop
    initial begin
        forever begin
            item_t it;
            int act;
            time t0;
            wait (pending > 0);
            it = sb[0];
            act = 0;
            case (it.kind)
                K_REG: begin
                    @(negedge clk);
                    reg_raddr = it.arg[0];
                    #1 act = int'(reg_rdata);
                end
                K_MPER: begin
                    @(posedge mclk); @(posedge mclk);
                    t0 = $time;
                    @(posedge mclk);
                    act = int'($time - t0);
                end
                K_SPER: begin
                    @(posedge smclk); @(posedge smclk);
                    t0 = $time;
                    @(posedge smclk);
                    act = int'($time - t0);
                end
                default: begin
                    @(negedge clk);
                    act = int'(nmi_req);
                end
            endcase
            compare(it.req, act, it.exp);
            void'(sb.pop_front());
            pending--;
        end
    end

    // runt-pulse monitors on both outputs (R9)
    bit   mon_on = 0;
    time  m_last = 0, s_last = 0;
    bit   m_valid = 0, s_valid = 0;
    int   m_runts = 0, s_runts = 0;

    always @(mclk) if (mon_on) begin
        if (m_valid && ($time - m_last) < DCO_HALF) m_runts++;
        m_last = $time; m_valid = 1;
    end

    always @(smclk) if (mon_on) begin
        if (s_valid && ($time - s_last) < DCO_HALF) s_runts++;
        s_last = $time; s_valid = 1;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        settle(6);
        rst_n = 1;
        settle(12);
        mon_on = 1;

        // R1 reset state
        push(K_REG, 0, 8'h00, "R1 ctrl after reset");
        push(K_REG, 1, 8'h01, "R1 status after reset");
        push(K_NMI, 0, 0, "R1 no request after reset");
        push(K_MPER, 0, 2*DCO_HALF, "R1 mclk on DCO");
        push(K_SPER, 0, 2*DCO_HALF, "R1 smclk on DCO");
        drain();

        // R3 select XT1 while flag set: still DCO
        wr(0, 4'h1); settle(20);
        push(K_MPER, 0, 2*DCO_HALF, "R3 override to DCO");
        push(K_REG, 0, 8'h01, "R4 select stored under override");
        drain();

        // R5 clear flag, R4 programmed source takes effect
        wr(1, 4'h0); settle(20);
        push(K_REG, 1, 8'h00, "R5 flag cleared");
        push(K_MPER, 0, 2*XT1_HALF, "R4 mclk on XT1");
        drain();

        wr(0, 4'h2); settle(20);
        push(K_MPER, 0, 2*XT2_HALF, "R4 mclk on XT2");
        drain();

        wr(0, 4'h3); settle(20);
        push(K_MPER, 0, 2*DCO_HALF, "R10 encoding 11 is DCO");
        drain();

        // R8 sub clock on XT2
        wr(0, 4'h6); settle(20);
        push(K_SPER, 0, 2*XT2_HALF, "R8 smclk on XT2");
        push(K_MPER, 0, 2*XT2_HALF, "R4 mclk back on XT2");
        drain();

        // R2 XT1 fault with set-over-clear priority
        osc_fault = 4'b0010; settle(5);
        push(K_REG, 1, 8'h05, "R2 XT1 fault readback");
        drain();
        settle(15);
        push(K_MPER, 0, 2*DCO_HALF, "R3 fault forces DCO");
        push(K_REG, 0, 8'h06, "R4 select unchanged by fault");
        push(K_SPER, 0, 2*XT2_HALF, "R8 smclk ignores flag");
        drain();
        wr(1, 4'h0); settle(2);
        push(K_REG, 1, 8'h05, "R5 set wins over clear");
        drain();
        osc_fault = 4'b0000; settle(5);
        push(K_REG, 1, 8'h01, "R2 flag latched after fault drops");
        drain();
        wr(1, 4'h0); settle(20);
        push(K_REG, 1, 8'h00, "R5 clear after fault gone");
        push(K_MPER, 0, 2*XT2_HALF, "R4 XT2 restored after clear");
        drain();

        // R2 each fault bit in its own position
        for (int i = 0; i < 4; i++) begin
            osc_fault = 4'(1 << i); settle(5);
            push(K_REG, 1, 1 | (2 << i), "R2 fault bit position");
            drain();
            osc_fault = 4'b0000; settle(5);
            wr(1, 4'h0); settle(5);
            push(K_REG, 1, 8'h00, "R5 clear after each fault");
            drain();
        end

        // R6 / R7 interrupt handshake
        wr(0, 4'hE); settle(3);
        push(K_NMI, 0, 0, "R6 enable without flag");
        drain();
        wr(1, 4'h1); settle(2);
        push(K_NMI, 0, 1, "R6 flag and enable");
        push(K_REG, 1, 8'h01, "R5 software set of flag");
        drain();
        @(negedge clk); nmi_ack = 1;
        @(negedge clk); nmi_ack = 0;
        settle(1);
        push(K_NMI, 0, 0, "R7 ack drops request");
        push(K_REG, 0, 8'h06, "R7 enable cleared by ack");
        push(K_REG, 1, 8'h01, "R7 flag kept after ack");
        drain();

        wr(1, 4'h0); settle(20);
        push(K_MPER, 0, 2*XT2_HALF, "R4 final restore");
        drain();

        compare("R9 mclk runt pulses", m_runts, 0);
        compare("R9 smclk runt pulses", s_runts, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule